// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the control piece that a small processor runs at every instruction boundary. It owns the program counter, the stack pointer and the global interrupt enable flag. When the core pulses end-of-instruction, the block samples the enable flag and the pending-interrupt status. If either one is clear, the program counter takes the address of the next instruction and fetch resumes at once. If both are set, the block runs a fixed three-cycle entry sequence in place of the next fetch.

The entry sequence has three steps. First, it moves the stack pointer down by one. Second, it writes the return address to memory at the new stack pointer. Third, it raises the acknowledge output for one cycle, during which the interrupting source drives its vector address. At the end of that cycle the vector is loaded into the program counter and the enable flag is cleared, so a nested request cannot enter until software sets the flag again. The busy output covers the whole sequence so that the core holds off fetch.

Top module: `irq_entry_seq`

## Requirements
- R1: A synchronous active-high reset sets `pc` to PC_RST, `sp` to SP_RST and `ien` to IEN_RST. It also drives `busy`, `int_ack` and `mem_we` low.
- R2: The flags are looked at only in a cycle where `eoi` is high. A pending `irq` with no `eoi` changes no output.
- R3: On `eoi` with `ien` low or `irq` low, `pc` takes `pc_next` on that edge, `busy` stays low and no memory write occurs.
- R4: On `eoi` with both `ien` and `irq` high, `busy` is high for exactly the three following cycles. It is low again in the fourth cycle.
- R5: In the first busy cycle the stack pointer is decremented by one, modulo 2^SW, so 0 becomes all ones. From the second busy cycle onward `sp` holds the new value.
- R6: In the second busy cycle `mem_we` is high for that one cycle only. `mem_addr` equals the decremented stack pointer and `mem_wdata` equals the `pc_next` value captured at `eoi`; for example, 750 is written when the interrupted instruction was at 749.
- R7: `int_ack` is high for exactly one cycle, the third busy cycle.
- R8: At the end of the acknowledge cycle, `pc` takes the value on `vec` in that cycle and `ien` is cleared. The clear holds even if `ien_set` is high in that same cycle.
- R9: `ien_clr` and `ien_set` act on the next edge, and clear wins when both are high. An `eoi` in the same cycle as `ien_set` or `ien_clr` is decided on the flag value from before that edge.
- R10: While `busy` is high, `eoi` pulses are ignored: they do not change `pc` and do not start a second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eoi | input | 1 | End-of-instruction pulse |
| pc_next | input | AW | Address of the next instruction |
| irq | input | 1 | Interrupt status, high when an unmasked request is pending |
| ien_set | input | 1 | Program request to set the enable flag |
| ien_clr | input | 1 | Program request to clear the enable flag |
| vec | input | AW | Vector address from the acknowledged source |
| pc | output | AW | Program counter |
| sp | output | SW | Stack pointer |
| ien | output | 1 | Interrupt enable flag |
| mem_we | output | 1 | Memory write strobe for the push |
| mem_addr | output | SW | Memory write address |
| mem_wdata | output | AW | Memory write data (return address) |
| int_ack | output | 1 | Interrupt acknowledge |
| busy | output | 1 | Entry sequence in progress |

## Verification
The flag check is tried with all four combinations of enable and status at a boundary, and with a pending request and no boundary. Together these show that entry needs both flags and a boundary. Boundaries that coincide with a flag set or clear show whether the decision uses the old flag value. Boundaries and set requests issued during the sequence show that the sequence cannot be re-entered and that its final clear holds. Two back-to-back entries starting from a zero stack pointer cover the wrap to all ones, the ordinary decrement, and the 749/750 return-address case.

// File: rtl/ent_pkg.sv
package ent_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEC  = 2'd1,
    ST_PUSH = 2'd2,
    ST_VEC  = 2'd3
  } ent_st_t;
endpackage

// File: rtl/ent_fsm.sv
module ent_fsm
  import ent_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic eoi,
  input  logic ien,
  input  logic irq,
  output logic eoi_take,
  output logic st_dec,
  output logic st_vec,
  output logic ack,
  output logic busy
);
  ent_st_t state;

  assign eoi_take = (state == ST_IDLE) && eoi;
  assign st_dec   = (state == ST_DEC);
  assign st_vec   = (state == ST_VEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ack   <= 1'b0;
      busy  <= 1'b0;
    end else begin
      ack <= (state == ST_PUSH);
      unique case (state)
        ST_IDLE: begin
          if (eoi && ien && irq) begin
            state <= ST_DEC;
            busy  <= 1'b1;
          end
        end
        ST_DEC:  state <= ST_PUSH;
        ST_PUSH: state <= ST_VEC;
        ST_VEC: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ent_stack.sv
module ent_stack #(
  parameter int AW     = 16,
  parameter int SW     = 8,
  parameter logic [SW-1:0] SP_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_dec,
  input  logic [AW-1:0] ret_pc,
  output logic [SW-1:0] sp,
  output logic          mem_we,
  output logic [SW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata
);
  logic [SW-1:0] sp_dn;
  assign sp_dn = sp - SW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp        <= SP_RST;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= st_dec;
      if (st_dec) begin
        sp        <= sp_dn;
        mem_addr  <= sp_dn;
        mem_wdata <= ret_pc;
      end
    end
  end
endmodule

// File: rtl/ent_pcreg.sv
module ent_pcreg #(
  parameter int AW = 16,
  parameter logic [AW-1:0] PC_RST  = '0,
  parameter logic          IEN_RST = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eoi_take,
  input  logic          st_vec,
  input  logic [AW-1:0] pc_next,
  input  logic [AW-1:0] vec,
  input  logic          ien_set,
  input  logic          ien_clr,
  output logic [AW-1:0] pc,
  output logic          ien
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= PC_RST;
      ien <= IEN_RST;
    end else begin
      if (st_vec)        pc <= vec;
      else if (eoi_take) pc <= pc_next;
      if (st_vec || ien_clr) ien <= 1'b0;
      else if (ien_set)      ien <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int AW = 16,
  parameter int SW = 8,
  parameter logic [AW-1:0] PC_RST  = 16'h0100,
  parameter logic [SW-1:0] SP_RST  = '0,
  parameter logic          IEN_RST = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eoi,
  input  logic [AW-1:0] pc_next,
  input  logic          irq,
  input  logic          ien_set,
  input  logic          ien_clr,
  input  logic [AW-1:0] vec,
  output logic [AW-1:0] pc,
  output logic [SW-1:0] sp,
  output logic          ien,
  output logic          mem_we,
  output logic [SW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  output logic          int_ack,
  output logic          busy
);
  logic eoi_take, st_dec, st_vec;

  ent_fsm u_fsm (
    .clk(clk), .rst(rst), .eoi(eoi), .ien(ien), .irq(irq),
    .eoi_take(eoi_take), .st_dec(st_dec), .st_vec(st_vec),
    .ack(int_ack), .busy(busy)
  );

  ent_stack #(.AW(AW), .SW(SW), .SP_RST(SP_RST)) u_stack (
    .clk(clk), .rst(rst), .st_dec(st_dec), .ret_pc(pc),
    .sp(sp), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  ent_pcreg #(.AW(AW), .PC_RST(PC_RST), .IEN_RST(IEN_RST)) u_pc (
    .clk(clk), .rst(rst), .eoi_take(eoi_take), .st_vec(st_vec),
    .pc_next(pc_next), .vec(vec), .ien_set(ien_set), .ien_clr(ien_clr),
    .pc(pc), .ien(ien)
  );
endmodule

// File: rtl/ent_chk.sv
module ent_chk #(
  parameter int AW = 16,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          eoi,
  input logic          irq,
  input logic [AW-1:0] vec,
  input logic [AW-1:0] pc,
  input logic [SW-1:0] sp,
  input logic          ien,
  input logic          mem_we,
  input logic [SW-1:0] mem_addr,
  input logic          int_ack,
  input logic          busy
);
  a_r7_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> !int_ack);

  a_r6_write_then_ack: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (!mem_we && int_ack));

  a_r6_addr_is_sp: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == sp));

  a_r5_sp_down_one: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> (sp == SW'($past(sp) - SW'(1))));

  a_r8_vector_load: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> (!ien && !busy && pc == $past(vec)));

  a_r3_no_entry: assert property (@(posedge clk) disable iff (rst)
    (eoi && !busy && !(ien && irq)) |=> !busy);

  a_r4_entry_starts: assert property (@(posedge clk) disable iff (rst)
    (eoi && !busy && ien && irq) |=> (busy && !mem_we && !int_ack));
endmodule

bind irq_entry_seq ent_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .eoi(eoi), .irq(irq), .vec(vec), .pc(pc),
  .sp(sp), .ien(ien), .mem_we(mem_we), .mem_addr(mem_addr),
  .int_ack(int_ack), .busy(busy)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  localparam int AW = 16;
  localparam int SW = 8;
  localparam int PCR = 'h0100;
  localparam int SMASK = (1 << SW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic eoi = 1'b0, irq = 1'b0, ien_set = 1'b0, ien_clr = 1'b0;
  logic [AW-1:0] pc_next = '0, vec = '0;
  logic [AW-1:0] pc, mem_wdata;
  logic [SW-1:0] sp, mem_addr;
  logic ien, mem_we, int_ack, busy;

  always #5 clk = ~clk;

  irq_entry_seq #(.AW(AW), .SW(SW)) u0 (
    .clk(clk), .rst(rst), .eoi(eoi), .pc_next(pc_next), .irq(irq),
    .ien_set(ien_set), .ien_clr(ien_clr), .vec(vec), .pc(pc), .sp(sp),
    .ien(ien), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .int_ack(int_ack), .busy(busy)
  );

  int n_chk = 0, n_bad = 0;
  int m_pc, m_sp, m_ph, m_addr, m_wd;
  bit m_ien, m_we, m_ack;

  // behavioural reference: phase 0 idle, 1..3 entry steps
  always @(posedge clk) begin
    if (rst) begin
      m_pc = PCR; m_sp = 0; m_ien = 0; m_ph = 0;
      m_we = 0; m_ack = 0; m_addr = 0; m_wd = 0;
    end else begin
      bit go;
      go = 0;
      m_we = 0; m_ack = 0;
      if (m_ph == 0 && eoi) begin
        m_pc = int'(pc_next);
        go = m_ien && irq;
      end
      if (ien_clr) m_ien = 0;
      else if (ien_set) m_ien = 1;
      case (m_ph)
        0: if (go) m_ph = 1;
        1: begin
          m_sp = (m_sp - 1) & SMASK;
          m_we = 1; m_addr = m_sp; m_wd = m_pc; m_ph = 2;
        end
        2: begin m_ack = 1; m_ph = 3; end
        default: begin m_pc = int'(vec); m_ien = 0; m_ph = 0; end
      endcase
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R8 R3 pc", int'(pc), m_pc);
    chk("R5 sp", int'(sp), m_sp);
    chk("R9 ien", int'(ien), int'(m_ien));
    chk("R6 mem_we", int'(mem_we), int'(m_we));
    if (m_we) begin
      chk("R6 mem_addr", int'(mem_addr), m_addr);
      chk("R6 mem_wdata", int'(mem_wdata), m_wd);
    end
    chk("R7 int_ack", int'(int_ack), int'(m_ack));
    chk("R4 busy", int'(busy), int'(m_ph != 0));
  endtask

  // one clock: inputs already set, compare after the edge, then clear pulses
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    eoi = 0; ien_set = 0; ien_clr = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1; tick(); tick();
    rst = 0;
    // R1 reset values
    chk("R1 pc", int'(pc), PCR);
    chk("R1 sp", int'(sp), 0);
    chk("R1 ien", int'(ien), 0);
    chk("R1 busy", int'(busy), 0);
    // R2: pending request, no boundary, enable set
    ien_set = 1; tick();
    irq = 1;
    for (int i = 0; i < 4; i++) tick();
    chk("R2 busy without eoi", int'(busy), 0);
    chk("R2 pc without eoi", int'(pc), PCR);
    // R3: boundary with status low
    irq = 0; eoi = 1; pc_next = 16'h0201; tick();
    chk("R3 pc loads next", int'(pc), 'h0201);
    chk("R3 no entry", int'(busy), 0);
    // R3: boundary with enable low (clear first)
    ien_clr = 1; tick();
    irq = 1; eoi = 1; pc_next = 16'h0202; tick();
    chk("R3 enable low no entry", int'(busy), 0);
    // R9: set and boundary together uses old (0) flag
    ien_set = 1; eoi = 1; pc_next = 16'h0203; tick();
    chk("R9 old flag decides", int'(busy), 0);
    chk("R9 flag now set", int'(ien), 1);
    // R9: set and clear together, clear wins
    ien_set = 1; ien_clr = 1; tick();
    chk("R9 clear wins", int'(ien), 0);
    ien_set = 1; tick();
    // R4 R5 R6: entry at instruction 749, returns to 750, sp wraps 0 -> 255
    eoi = 1; pc_next = 16'd750; vec = 16'h0040; tick();
    chk("R4 busy step1", int'(busy), 1);
    eoi = 1; pc_next = 16'h0999; tick();          // R10 boundary ignored
    chk("R5 sp wrapped", int'(sp), SMASK);
    chk("R6 write strobe", int'(mem_we), 1);
    chk("R6 pushed 750", int'(mem_wdata), 750);
    chk("R10 pc unchanged", int'(pc), 750);
    vec = 16'h0044; tick();
    chk("R7 ack", int'(int_ack), 1);
    ien_set = 1; vec = 16'h0048; tick();          // R8 set in ack cycle
    chk("R8 vector", int'(pc), 'h0048);
    chk("R8 ien cleared", int'(ien), 0);
    chk("R4 busy low", int'(busy), 0);
    // second entry: sp 255 -> 254
    ien_set = 1; tick();
    eoi = 1; pc_next = 16'h1234; vec = 16'h0080; tick();
    for (int i = 0; i < 3; i++) tick();
    chk("R5 sp second", int'(sp), SMASK - 1);
    chk("R8 second vector", int'(pc), 'h0080);
    // idle boundaries with varied patterns
    for (int i = 0; i < 8; i++) begin
      eoi = 1; irq = i[0]; pc_next = AW'(16'h3000 + i);
      if (i[1]) ien_set = 1;
      tick(); tick();
    end
    for (int i = 0; i < 4; i++) tick();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule